// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block makes the keep-or-drop decision for each received Ethernet frame. Upstream logic presents the frame's destination address, a precomputed 6-bit multicast hash index, the frame byte count and two error flags (CRC mismatch and misalignment). It raises an end-of-frame strobe while these are valid. One clock later the block reports whether the frame is accepted, whether it should be written to the receive buffer, and a status byte that describes the frame.

The filter keeps its own station address, a 64-entry multicast hash table and a receive configuration byte. Each of these is loaded through a plain write strobe. The configuration selects which address classes pass: unicast to the station only or any unicast, broadcast, and hashed multicast. It also decides whether short frames and errored frames are kept. A monitor mode runs the full check on each frame but never stores it.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, `dec_valid`, `accept` and `store` are 0, `rx_status` is 0x00, and the station address, hash table and configuration are all zero.
- R2: A decision appears on the cycle after `eof` is sampled high, with `dec_valid` = 1 for exactly that cycle. `accept` and `store` are 1 only while `dec_valid` is 1.
- R3: A frame whose group bit (`dst_addr[40]`, the LSB of the first address byte `dst_addr[47:40]`) is 0 is a unicast frame. With configuration bit 4 (promiscuous) clear, it passes the address check only when it equals the station address. With bit 4 set, every unicast frame passes.
- R4: The all-ones destination address is broadcast. It passes the address check only when configuration bit 2 is set.
- R5: A group-bit frame that is not broadcast passes the address check only when configuration bit 3 is set and hash table bit `hash_idx` (bit n of `hash_in` is table entry n) is 1.
- R6: A frame with `byte_cnt` below 64 is rejected unless configuration bit 1 is set. A count of exactly 64 is not a runt.
- R7: A frame with `crc_err` or `align_err` set is rejected unless configuration bit 0 is set.
- R8: With configuration bit 5 (monitor) set, `store` stays 0. `rx_status` bit 6 is 1 for every decision, and bit 4 (missed) is 1 when the frame otherwise passes every check.
- R9: `rx_status` is captured at each decision and held until the next one. Bit 0 means accepted with no error. Bit 1 is set by a CRC error or by an alignment error. Bit 2 means alignment error. Bit 5 means accepted through a group (multicast or broadcast) match. Bits 3 and 7 read 0.
- R10: `accept` = address check, length check and error check all passing, and `store` = `accept` with monitor clear. Configuration bits 6 and 7 are stored but have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| station_we | input | 1 | Load station address |
| station_in | input | 48 | Station address value |
| hash_we | input | 1 | Load multicast hash table |
| hash_in | input | 64 | Hash table value, bit n is entry n |
| rcfg_we | input | 1 | Load receive configuration |
| rcfg_in | input | 8 | Receive configuration value |
| eof | input | 1 | End-of-frame strobe, frame fields valid |
| dst_addr | input | 48 | Destination address, first byte in [47:40] |
| hash_idx | input | 6 | Multicast hash index |
| byte_cnt | input | 16 | Frame byte count |
| crc_err | input | 1 | CRC mismatch |
| align_err | input | 1 | Frame did not end on a byte boundary |
| dec_valid | output | 1 | Decision valid pulse |
| accept | output | 1 | Frame accepted |
| store | output | 1 | Write frame to buffer |
| rx_status | output | 8 | Frame status byte |

## Verification
The assertions compare each decision with the configuration and frame fields present at the `eof` edge. They therefore assume that the frame fields stay stable during that cycle and that the configuration is not rewritten in the same cycle as `eof`. The stimulus loads all configuration before it raises `eof`, drives every input on the falling clock edge, and holds each frame for a single strobe cycle. This keeps the stimulus within those assumptions.

// File: rtl/rx_addr_filter.sv
module rx_addr_filter #(
  parameter int CNT_W     = 16,
  parameter int MIN_LEN   = 64,
  parameter int HASH_BITS = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 station_we,
  input  logic [47:0]          station_in,
  input  logic                 hash_we,
  input  logic [63:0]          hash_in,
  input  logic                 rcfg_we,
  input  logic [7:0]           rcfg_in,
  input  logic                 eof,
  input  logic [47:0]          dst_addr,
  input  logic [HASH_BITS-1:0] hash_idx,
  input  logic [CNT_W-1:0]     byte_cnt,
  input  logic                 crc_err,
  input  logic                 align_err,
  output logic                 dec_valid,
  output logic                 accept,
  output logic                 store,
  output logic [7:0]           rx_status
);
  localparam int HASH_N = 1 << HASH_BITS;

  logic [47:0]       station_q;
  logic [HASH_N-1:0] hash_q;
  logic [7:0]        cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      station_q <= '0;
      hash_q    <= '0;
      cfg_q     <= '0;
    end else begin
      if (station_we) station_q <= station_in;
      if (hash_we)    hash_q    <= hash_in[HASH_N-1:0];
      if (rcfg_we)    cfg_q     <= rcfg_in;
    end
  end

  wire keep_err = cfg_q[0];
  wire keep_runt = cfg_q[1];
  wire take_bc = cfg_q[2];
  wire take_mc = cfg_q[3];
  wire promisc = cfg_q[4];
  wire monitor = cfg_q[5];

  wire is_group = dst_addr[40];
  wire is_bcast = &dst_addr;
  wire is_mcast = is_group && !is_bcast;

  wire addr_ok = (is_bcast && take_bc)
              || (is_mcast && take_mc && hash_q[hash_idx])
              || (!is_group && (promisc || dst_addr == station_q));
  wire any_err = crc_err || align_err;
  wire len_ok  = keep_runt || (byte_cnt >= CNT_W'(MIN_LEN));
  wire err_ok  = keep_err || !any_err;
  wire pass    = addr_ok && len_ok && err_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid <= 1'b0;
      accept    <= 1'b0;
      store     <= 1'b0;
      rx_status <= '0;
    end else begin
      dec_valid <= eof;
      accept    <= eof && pass;
      store     <= eof && pass && !monitor;
      if (eof)
        rx_status <= {1'b0, monitor, pass && is_group, pass && monitor,
                      1'b0, align_err, any_err, pass && !any_err};
    end
  end
endmodule

module rx_addr_filter_chk #(
  parameter int CNT_W   = 16,
  parameter int MIN_LEN = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             eof,
  input logic [47:0]      dst_addr,
  input logic [CNT_W-1:0] byte_cnt,
  input logic             crc_err,
  input logic             align_err,
  input logic [7:0]       cfg_q,
  input logic             dec_valid,
  input logic             accept,
  input logic             store,
  input logic [7:0]       rx_status
);
  assert_valid_follows_eof_R2: assert property (@(posedge clk) disable iff (!rst_n)
    eof |=> dec_valid);
  assert_accept_in_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> dec_valid);
  assert_store_needs_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    store |-> accept);
  assert_bcast_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (eof && (&dst_addr) && !cfg_q[2]) |=> !accept);
  assert_runt_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (eof && byte_cnt < CNT_W'(MIN_LEN) && !cfg_q[1]) |=> !accept);
  assert_err_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (eof && (crc_err || align_err) && !cfg_q[0]) |=> !accept);
  assert_monitor_nostore_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (eof && cfg_q[5]) |=> (!store && rx_status[6]));
  assert_align_implies_crc_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_status[2] |-> rx_status[1]);
endmodule

bind rx_addr_filter rx_addr_filter_chk #(.CNT_W(CNT_W), .MIN_LEN(MIN_LEN)) chk_i (
  .clk(clk), .rst_n(rst_n), .eof(eof), .dst_addr(dst_addr), .byte_cnt(byte_cnt),
  .crc_err(crc_err), .align_err(align_err), .cfg_q(cfg_q), .dec_valid(dec_valid),
  .accept(accept), .store(store), .rx_status(rx_status));

// File: tb/rx_addr_filter_tb.sv
module rx_addr_filter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        station_we = 0, hash_we = 0, rcfg_we = 0, eof = 0, crc_err = 0, align_err = 0;
  logic [47:0] station_in = '0, dst_addr = '0;
  logic [63:0] hash_in = '0;
  logic [7:0]  rcfg_in = '0;
  logic [5:0]  hash_idx = '0;
  logic [15:0] byte_cnt = '0;
  logic        dec_valid, accept, store;
  logic [7:0]  rx_status;
  int          errors = 0, checks = 0;

  localparam logic [47:0] ME    = 48'h02_11_22_33_44_55;
  localparam logic [47:0] OTHER = 48'h02_AA_BB_CC_DD_EE;
  localparam logic [47:0] BC    = 48'hFF_FF_FF_FF_FF_FF;
  localparam logic [47:0] MC    = 48'h01_00_5E_00_00_01;

  always #2.5 clk = ~clk;

  rx_addr_filter dut_i (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_cfg(logic [7:0] c);
    @(negedge clk); rcfg_in = c; rcfg_we = 1;
    @(negedge clk); rcfg_we = 0;
  endtask

  task automatic frame(string req, logic [47:0] a, logic [5:0] idx, logic [15:0] n,
                       logic ce, logic ae, logic ea, logic es, logic [7:0] est);
    @(negedge clk);
    dst_addr = a; hash_idx = idx; byte_cnt = n; crc_err = ce; align_err = ae; eof = 1;
    @(negedge clk);
    eof = 0;
    check({req, " valid"}, dec_valid, 1);
    check({req, " accept"}, accept, ea);
    check({req, " store"}, store, es);
    check({req, " status"}, rx_status, est);
  endtask

  task automatic t_reset();
    check("R1 valid", dec_valid, 0);
    check("R1 accept", accept, 0);
    check("R1 status", rx_status, 0);
    frame("R1 zero cfg", OTHER, 0, 100, 0, 0, 0, 0, 8'h00);
  endtask

  task automatic t_load();
    @(negedge clk);
    station_in = ME; station_we = 1; hash_in = 64'h0000_0000_0000_0020; hash_we = 1;
    @(negedge clk); station_we = 0; hash_we = 0;
  endtask

  task automatic t_unicast();
    set_cfg(8'h00);
    frame("R3 match", ME, 0, 100, 0, 0, 1, 1, 8'h01);
    frame("R3 nomatch", OTHER, 0, 100, 0, 0, 0, 0, 8'h00);
    set_cfg(8'h10);
    frame("R3 promisc", OTHER, 0, 100, 0, 0, 1, 1, 8'h01);
  endtask

  task automatic t_broadcast();
    set_cfg(8'h00);
    frame("R4 bc off", BC, 5, 100, 0, 0, 0, 0, 8'h00);
    set_cfg(8'h04);
    frame("R4 bc on", BC, 0, 100, 0, 0, 1, 1, 8'h21);
  endtask

  task automatic t_multicast();
    set_cfg(8'h08);
    frame("R5 hit", MC, 5, 100, 0, 0, 1, 1, 8'h21);
    frame("R5 miss", MC, 6, 100, 0, 0, 0, 0, 8'h00);
    set_cfg(8'h14);
    frame("R5 am off", MC, 5, 100, 0, 0, 0, 0, 8'h00);
  endtask

  task automatic t_runt();
    set_cfg(8'h00);
    frame("R6 len63", ME, 0, 63, 0, 0, 0, 0, 8'h00);
    frame("R6 len64", ME, 0, 64, 0, 0, 1, 1, 8'h01);
    set_cfg(8'h02);
    frame("R6 runt kept", ME, 0, 20, 0, 0, 1, 1, 8'h01);
  endtask

  task automatic t_errors();
    set_cfg(8'h00);
    frame("R7 crc drop", ME, 0, 100, 1, 0, 0, 0, 8'h02);
    frame("R7 align drop", ME, 0, 100, 0, 1, 0, 0, 8'h06);
    set_cfg(8'h01);
    frame("R7 crc kept", ME, 0, 100, 1, 0, 1, 1, 8'h02);
    frame("R9 align kept", ME, 0, 100, 0, 1, 1, 1, 8'h06);
  endtask

  task automatic t_monitor();
    set_cfg(8'h20);
    frame("R8 mon pass", ME, 0, 100, 0, 0, 1, 0, 8'h51);
    frame("R8 mon fail", OTHER, 0, 100, 0, 0, 0, 0, 8'h40);
  endtask

  task automatic t_hold();
    set_cfg(8'h04);
    frame("R9 bc", BC, 0, 100, 0, 0, 1, 1, 8'h21);
    @(negedge clk);
    check("R2 valid pulse", dec_valid, 0);
    check("R2 accept drop", accept, 0);
    check("R9 status held", rx_status, 8'h21);
  endtask

  task automatic t_upper();
    set_cfg(8'hC0);
    frame("R10 upper bits", ME, 0, 100, 0, 0, 1, 1, 8'h01);
    frame("R10 upper bits bc", BC, 0, 100, 0, 0, 0, 0, 8'h00);
  endtask

  initial begin
    #100000;
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_load();
    t_unicast();
    t_broadcast();
    t_multicast();
    t_runt();
    t_errors();
    t_monitor();
    t_hold();
    t_upper();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule